// File: doc/BRIEF.md
# Two-State Write-Through Snooping Cache Controller

This block keeps a small direct-mapped cache coherent on a shared snooping bus using only two line states, Valid and Invalid. A core presents loads and stores on a request port and holds each request until it is acknowledged. Loads that find a matching Valid line finish in the same cycle without touching the bus; a load that misses fetches the word with a shared-read request and installs it. Every store, hit or miss, is written through to the bus as an exclusive-write request. A store that misses leaves the cache unchanged, and a store that hits refreshes the local copy as it starts its bus write.

A separate snoop port shows the controller the requests that other caches place on the bus. A remote shared read leaves everything alone. A remote exclusive write to an address held Valid here silently drops that line. Each line holds one data word, so a full address is an index plus a tag. Arbitration and memory timing are outside the block: a single acknowledge input marks the cycle in which the outstanding bus request has been granted and finished, and it carries read data for a shared read.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, cpu_ack and bus_req are low, and the first load to any address misses.
- R2: When idle, a load whose address matches a Valid line raises cpu_ack in the same cycle with that line's data and raises no bus_req.
- R3: A load miss raises bus_req the next cycle with bus_cmd=0 (shared read) and the load address; in the cycle bus_ack is high, cpu_ack rises with cpu_rdata equal to bus_rdata, and the line becomes Valid holding that data.
- R4: Every store, hit or miss, raises bus_req the next cycle with bus_cmd=1 (exclusive write), the store address and data, and is acknowledged to the core in the cycle bus_ack is high.
- R5: A store miss does not allocate: a later load to that address still misses.
- R6: A store hit writes its data into the local line in the cycle it is accepted; the line stays Valid, so a later load hits with the new data.
- R7: A snooped shared read (snp_cmd=0) changes no line state.
- R8: A snooped exclusive write (snp_cmd=1) whose address matches a Valid line makes it Invalid; a Valid line at the same index with a different tag is unaffected.
- R9: When a snooped exclusive write and a local load name the same address in the same cycle, the snoop takes effect first and the load is handled as a miss.
- R10: While a bus request is outstanding, bus_req stays high with bus_cmd, bus_addr and bus_wdata unchanged, and cpu_ack stays low until bus_ack.
- R11: The cache is direct mapped on the low IDX_W address bits: a fill replaces whatever line held that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core request valid, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request complete this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| bus_req | output | 1 | Bus request outstanding |
| bus_cmd | output | 1 | 0 = shared read, 1 = exclusive write |
| bus_addr | output | ADDR_W | Bus request address |
| bus_wdata | output | DATA_W | Write-through data |
| bus_ack | input | 1 | Bus request granted and finished this cycle |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| snp_valid | input | 1 | Another cache's request is visible this cycle |
| snp_cmd | input | 1 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
The two functions that can meet in one cycle are a snoop and a local access to the same line: a remote exclusive write can arrive in the very cycle a load looks up that address, or while a store hit is waiting on its bus write. The bench provokes this by driving the snoop port in the first cycle of a load or store to a line it has just filled, and also to a same-index line with another tag. A behavioural model applies the snoop before the local access, so it predicts a miss for the colliding load and an invalid line afterwards; the bus outputs and acknowledges are compared against it every clock.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic {
    CMD_SHRD = 1'b0,
    CMD_EXCL = 1'b1
  } bus_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  input  logic [TAG_W-1:0]  inv_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // snoop invalidation first, local install second
  always_comb begin
    valid_d = valid_q;
    if (inv_en && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag))
      valid_d[inv_idx] = 1'b0;
    if (wr_en)
      valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_we) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end
  end

  // R8
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag) &&
     !(wr_en && (wr_idx == inv_idx)))
    |=> !valid_q[$past(inv_idx)]);

  // R3
  install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && (data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              hit,
  input  logic [DATA_W-1:0] line_data,
  output logic              bus_req,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  ctrl_state_e       state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;

  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    cpu_ack   = 1'b0;
    cpu_rdata = line_data;
    wr_en     = 1'b0;
    wr_addr   = cpu_addr;
    wr_data   = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (!cpu_we && hit) begin
            cpu_ack = 1'b1;
          end else begin
            accept  = 1'b1;
            state_d = ST_BUSY;
            wr_en   = cpu_we && hit;
          end
        end
      end
      ST_BUSY: begin
        if (bus_ack) begin
          cpu_ack   = 1'b1;
          cpu_rdata = bus_rdata;
          wr_en     = !we_q;
          wr_addr   = addr_q;
          wr_data   = bus_rdata;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      we_q    <= cpu_we;
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  assign bus_req   = (state_q == ST_BUSY);
  assign bus_cmd   = we_q ? CMD_EXCL : CMD_SHRD;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_cmd)
                              && $stable(bus_wdata));

  // R4
  store_to_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && cpu_req && cpu_we) |=> bus_req && (bus_cmd == CMD_EXCL));

  // R10
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req);
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic              bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              snp_kill, snp_same, hit;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign snp_kill = snp_valid && (snp_cmd == CMD_EXCL);
  assign snp_same = snp_kill && (snp_addr == cpu_addr);
  assign hit      = rd_valid && (rd_tag == cpu_addr[ADDR_W-1:IDX_W]) && !snp_same;

  wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (cpu_addr[IDX_W-1:0]),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_data (rd_data),
    .inv_en  (snp_kill),
    .inv_idx (snp_addr[IDX_W-1:0]),
    .inv_tag (snp_addr[ADDR_W-1:IDX_W]),
    .wr_en   (wr_en),
    .wr_idx  (wr_addr[IDX_W-1:0]),
    .wr_tag  (wr_addr[ADDR_W-1:IDX_W]),
    .wr_data (wr_data)
  );

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_ack  (cpu_ack),
    .cpu_rdata(cpu_rdata),
    .hit      (hit),
    .line_data(rd_data),
    .bus_req  (bus_req),
    .bus_cmd  (bus_cmd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // R9
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && cpu_req && !cpu_we && snp_same) |-> !cpu_ack);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !bus_ack) |-> !bus_req);
endmodule

// File: tb/wt_snoop_cache_test.sv
module wt_snoop_cache_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;
  logic snp_valid, snp_cmd;
  logic [AW-1:0] snp_addr;

  always #5 clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) uut (.*);

  int tests = 0;
  int fails = 0;
  string ctx = "R1";

  // behavioural model
  bit          c_v [NL];
  int          c_a [NL];
  int          c_d [NL];
  logic [DW-1:0] mem [int];
  bit          m_busy;
  bit          m_we;
  int          m_addr;
  int          m_wdata;
  int          wait_cnt;
  int          lat;
  bit          e_ack;

  function automatic logic [DW-1:0] mem_rd(input int a);
    if (mem.exists(a)) return mem[a];
    return {a[7:0], ~a[7:0]};
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", ctx, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit hit_e, e_breq;
    int idx;
    int e_rd;
    bus_ack   = m_busy && (wait_cnt >= lat);
    bus_rdata = m_busy ? mem_rd(m_addr) : '0;
    #1;
    idx   = int'(cpu_addr) % NL;
    hit_e = c_v[idx] && (c_a[idx] == int'(cpu_addr)) &&
            !(snp_valid && snp_cmd && (snp_addr == cpu_addr));
    e_breq = m_busy;
    if (!m_busy) begin
      e_ack = cpu_req && !cpu_we && hit_e;
      e_rd  = c_d[idx];
    end else begin
      e_ack = bus_ack;
      e_rd  = int'(bus_rdata);
    end
    #3;
    chk(bus_req == e_breq, "bus_req", int'(bus_req), int'(e_breq));
    if (e_breq) begin
      chk(bus_cmd == m_we, "bus_cmd", int'(bus_cmd), int'(m_we));
      chk(int'(bus_addr) == m_addr, "bus_addr", int'(bus_addr), m_addr);
      if (m_we) chk(int'(bus_wdata) == m_wdata, "bus_wdata", int'(bus_wdata), m_wdata);
    end
    chk(cpu_ack == e_ack, "cpu_ack", int'(cpu_ack), int'(e_ack));
    if (e_ack && !(m_busy && m_we))
      chk(int'(cpu_rdata) == e_rd, "cpu_rdata", int'(cpu_rdata), e_rd);
    @(posedge clk);
    // snoop is applied before the local access
    if (snp_valid && snp_cmd) begin
      int si = int'(snp_addr) % NL;
      if (c_v[si] && c_a[si] == int'(snp_addr)) c_v[si] = 1'b0;
    end
    if (!m_busy) begin
      if (cpu_req && !(!cpu_we && hit_e)) begin
        m_busy = 1'b1; m_we = cpu_we; m_addr = int'(cpu_addr);
        m_wdata = int'(cpu_wdata); wait_cnt = 0;
        if (cpu_we && hit_e) c_d[idx] = int'(cpu_wdata);
      end
    end else if (bus_ack) begin
      if (m_we) mem[m_addr] = DW'(m_wdata);
      else begin
        c_v[m_addr % NL] = 1'b1; c_a[m_addr % NL] = m_addr;
        c_d[m_addr % NL] = int'(bus_rdata);
      end
      m_busy = 1'b0;
    end else begin
      wait_cnt++;
    end
    @(negedge clk);
  endtask

  task automatic run_op(input bit we, input int a, input int wd, input int l,
                        input bit sv, input bit sc, input int sa);
    int n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    snp_valid = sv; snp_cmd = sc; snp_addr = AW'(sa);
    lat = l;
    do begin
      cycle();
      snp_valid = 1'b0;
      n++;
    end while (!e_ack && n < 40);
    if (n >= 40) chk(1'b0, "op timeout", n, 40);
    cpu_req = 1'b0;
    cycle();
  endtask

  task automatic snoop(input bit sc, input int sa);
    snp_valid = 1'b1; snp_cmd = sc; snp_addr = AW'(sa);
    cycle();
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (c_v[i]) begin c_v[i] = 1'b0; c_a[i] = 0; c_d[i] = 0; end
    m_busy = 1'b0; m_we = 1'b0; m_addr = 0; m_wdata = 0; wait_cnt = 0; lat = 1;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_ack = 1'b0; bus_rdata = '0; snp_valid = 1'b0; snp_cmd = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctx = "R1";
    cycle(); cycle();
    run_op(1'b0, 'h10, 0, 1, 1'b0, 1'b0, 0);       // R1 first load misses
    ctx = "R3"; run_op(1'b0, 'h12, 0, 2, 1'b0, 1'b0, 0);
    ctx = "R2"; run_op(1'b0, 'h12, 0, 0, 1'b0, 1'b0, 0);
    ctx = "R6"; run_op(1'b1, 'h12, 'hBEEF, 1, 1'b0, 1'b0, 0);
    run_op(1'b0, 'h12, 0, 0, 1'b0, 1'b0, 0);
    ctx = "R5"; run_op(1'b1, 'h33, 'h1234, 0, 1'b0, 1'b0, 0);
    run_op(1'b0, 'h33, 0, 1, 1'b0, 1'b0, 0);
    ctx = "R7"; run_op(1'b0, 'h21, 0, 1, 1'b0, 1'b0, 0);
    snoop(1'b0, 'h21);
    run_op(1'b0, 'h21, 0, 0, 1'b0, 1'b0, 0);
    ctx = "R8"; snoop(1'b1, 'h25);
    run_op(1'b0, 'h21, 0, 0, 1'b0, 1'b0, 0);
    snoop(1'b1, 'h21);
    run_op(1'b0, 'h21, 0, 1, 1'b0, 1'b0, 0);
    ctx = "R9"; run_op(1'b0, 'h21, 0, 2, 1'b1, 1'b1, 'h21);
    run_op(1'b0, 'h21, 0, 0, 1'b0, 1'b0, 0);
    ctx = "R8"; run_op(1'b1, 'h21, 'h5A5A, 3, 1'b1, 1'b1, 'h21);
    run_op(1'b0, 'h21, 0, 1, 1'b0, 1'b0, 0);
    ctx = "R4"; run_op(1'b1, 'h12, 'h0F0F, 4, 1'b1, 1'b1, 'h12);
    run_op(1'b0, 'h12, 0, 1, 1'b0, 1'b0, 0);
    ctx = "R10"; run_op(1'b0, 'h44, 0, 6, 1'b1, 1'b0, 'h44);
    run_op(1'b1, 'h44, 'hC3C3, 5, 1'b0, 1'b0, 0);
    ctx = "R11"; run_op(1'b0, 'h02, 0, 1, 1'b0, 1'b0, 0);
    run_op(1'b0, 'h06, 0, 1, 1'b0, 1'b0, 0);
    run_op(1'b0, 'h02, 0, 1, 1'b0, 1'b0, 0);
    run_op(1'b0, 'h02, 0, 0, 1'b0, 1'b0, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule